// File: doc/BRIEF.md
# Selectable Output Scaler with Saturation

This block sits at the tail of a transform pipeline and narrows each 15-bit two's complement real and imaginary result to 12 bits. A 2-bit select code picks which 12-bit slice of the wide word is kept, so the same hardware can serve signals of very different magnitude. The bits below the slice are dropped. If the bits above the slice do not all match the slice's sign bit, the value cannot be represented. In that case the component is clamped to the largest positive or largest negative 12-bit code instead of wrapping.

Results arrive as a stream of 64-sample blocks, each sample qualified by a valid strobe. A start marker flags the first sample of a block. A sticky overflow flag reports whether any component of the current block has been clamped. It is reloaded at each block boundary. A boundary is either a marked sample or the first valid sample after 64 samples without a marker. Data, valid and flag all appear one clock after the input sample.

Top module: `out_scaler_sat`

## Requirements
- R1: While the asynchronous active-high reset is asserted, `outValid`, `outOvf`, `outRe` and `outIm` are all zero.
- R2: `outValid` is high exactly one clock after a cycle with `inValid` high, and the 12-bit outputs for that sample appear in the same cycle as that `outValid`.
- R3: The select code picks the kept slice of the 15-bit word: code 0 keeps bits [14:3], code 1 keeps [13:2], code 2 keeps [12:1], code 3 keeps [11:0]. The dropped low bits are discarded, which truncates toward minus infinity.
- R4: With code 0 no component ever saturates and the overflow flag is never set by that sample.
- R5: A positive value too large for the selected slice is output as 0x7FF.
- R6: A negative value too large in magnitude for the selected slice is output as 0x800. The most negative value that fits is passed through unchanged, not treated as overflow.
- R7: Real and imaginary parts are range-checked and clamped independently: clamping one leaves the other's correctly scaled value intact.
- R8: When either component of a valid sample is clamped, `outOvf` is high in the same output cycle as that sample.
- R9: Once set, `outOvf` stays high for all later samples of the same block, whether or not they are in range.
- R10: On the first sample of a block, `outOvf` takes that sample's own overflow status: it drops if the sample fits and stays or goes high if it does not.
- R11: After 64 valid samples since the last block start, the next valid sample begins a new block even when `inBlockStart` is low. The first valid sample after reset also begins a block.
- R12: Cycles with `inValid` low change neither the 12-bit outputs nor `outOvf`, whatever values are on the data and select inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| shiftSel | input | 2 | Code selecting the kept 12-bit slice |
| inValid | input | 1 | Input sample qualifier |
| inBlockStart | input | 1 | Marks the first sample of a block |
| inRe | input | 15 | Real part, two's complement |
| inIm | input | 15 | Imaginary part, two's complement |
| outValid | output | 1 | Output sample qualifier |
| outRe | output | 12 | Scaled and clamped real part |
| outIm | output | 12 | Scaled and clamped imaginary part |
| outOvf | output | 1 | Sticky per-block overflow flag |

## Verification
The block-boundary reload of the overflow flag and the sticky setting of that flag can fall on the same sample. This happens when the first sample of a block itself overflows. The bench provokes it in two ways: with an explicit marker on an overflowing sample while the flag is already low, and with a 65th marker-less sample that either fits or clamps. It judges the outcome by the flag in the output cycle of that sample. The flag must follow only that sample's status, never the previous block's. The same sequences also check that clamping one component leaves the other's scaled value intact.

// File: rtl/oscale_pkg.sv
package oscale_pkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic capture;   // a valid sample is taken this cycle
    logic newBlock;  // that sample opens a new block
  } scaleStrobe_t;

endpackage

// File: rtl/oscale_ctrl.sv
module oscale_ctrl
  import oscale_pkg::*;
#(
  parameter int BLOCK_LEN = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         inBlockStart,
  output scaleStrobe_t strobe
);

  localparam int CNT_W = $clog2(BLOCK_LEN + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BLOCK_LEN);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  // Samples taken since the last block start; resets to FULL so the first
  // sample after reset opens a block.
  logic [CNT_W-1:0] seenCount;

  always_comb begin
    strobe.capture  = inValid;
    strobe.newBlock = inValid && (inBlockStart || (seenCount == FULL_CNT));
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      seenCount <= FULL_CNT;
    end else if (inValid) begin
      if (strobe.newBlock) seenCount <= ONE_CNT;
      else                 seenCount <= seenCount + ONE_CNT;
    end
  end

  // R11: a block start always restarts the sample count at one
  p_restart_r11: assert property (@(posedge clk) disable iff (rst)
    strobe.newBlock |=> (seenCount == ONE_CNT));

  // R11: the count never leaves the range 1..BLOCK_LEN
  p_count_bound_r11: assert property (@(posedge clk) disable iff (rst)
    (seenCount != '0) && (seenCount <= FULL_CNT));

endmodule

// File: rtl/oscale_lane.sv
module oscale_lane #(
  parameter int IN_W  = 15,
  parameter int OUT_W = 12,
  parameter int SEL_W = 2
) (
  input  logic [IN_W-1:0]  din,
  input  logic [SEL_W-1:0] sel,
  output logic [OUT_W-1:0] dout,
  output logic             ovf
);

  localparam int SHIFT_MAX = IN_W - OUT_W;
  localparam int HEAD_W    = IN_W - OUT_W + 1;
  localparam logic [OUT_W-1:0] POS_LIMIT = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_LIMIT = {1'b1, {(OUT_W-1){1'b0}}};

  int                     shiftAmt;
  logic signed [IN_W-1:0] shifted;
  logic [HEAD_W-1:0]      headBits;

  always_comb begin
    // higher code keeps a lower slice, i.e. shifts down less
    if (int'(sel) > SHIFT_MAX) shiftAmt = 0;
    else                       shiftAmt = SHIFT_MAX - int'(sel);
    shifted  = $signed(din) >>> shiftAmt;
    // the kept sign bit and everything above it must agree
    headBits = shifted[IN_W-1:OUT_W-1];
    ovf      = (|headBits) && !(&headBits);
    if (ovf) dout = din[IN_W-1] ? NEG_LIMIT : POS_LIMIT;
    else     dout = shifted[OUT_W-1:0];
  end

endmodule

// File: rtl/oscale_dp.sv
module oscale_dp
  import oscale_pkg::*;
#(
  parameter int IN_W  = 15,
  parameter int OUT_W = 12,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  scaleStrobe_t     strobe,
  input  logic [SEL_W-1:0] sel,
  input  logic [IN_W-1:0]  inRe,
  input  logic [IN_W-1:0]  inIm,
  output logic [OUT_W-1:0] outRe,
  output logic [OUT_W-1:0] outIm,
  output logic             outValid,
  output logic             outOvf
);

  localparam int LANES = 2;
  localparam logic [OUT_W-1:0] POS_LIMIT = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_LIMIT = {1'b1, {(OUT_W-1){1'b0}}};

  logic [LANES-1:0][IN_W-1:0]  laneIn;
  logic [LANES-1:0][OUT_W-1:0] laneOut;
  logic [LANES-1:0]            laneOvf;
  logic                        anyOvf;

  assign laneIn[0] = inRe;
  assign laneIn[1] = inIm;
  assign anyOvf    = |laneOvf;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    oscale_lane #(
      .IN_W (IN_W),
      .OUT_W(OUT_W),
      .SEL_W(SEL_W)
    ) uLane (
      .din (laneIn[g]),
      .sel (sel),
      .dout(laneOut[g]),
      .ovf (laneOvf[g])
    );
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      outRe    <= '0;
      outIm    <= '0;
      outValid <= 1'b0;
      outOvf   <= 1'b0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        outRe <= laneOut[0];
        outIm <= laneOut[1];
        if (strobe.newBlock) outOvf <= anyOvf;
        else                 outOvf <= outOvf | anyOvf;
      end
    end
  end

  // R2: every captured sample produces an output strobe one cycle later
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> outValid);

  // R5: a clamped real part is one of the two limit codes
  p_clamp_re_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && laneOvf[0]) |=> ((outRe == POS_LIMIT) || (outRe == NEG_LIMIT)));

  // R6: a clamped imaginary part is one of the two limit codes
  p_clamp_im_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && laneOvf[1]) |=> ((outIm == POS_LIMIT) || (outIm == NEG_LIMIT)));

  // R9: inside a block the flag never falls
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && !strobe.newBlock && outOvf) |=> outOvf);

  // R8: any clamped component raises the flag with its sample
  p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && anyOvf) |=> outOvf);

  // R12: idle cycles leave data and flag untouched
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> ($stable(outRe) && $stable(outIm) && $stable(outOvf)));

endmodule

// File: rtl/out_scaler_sat.sv
module out_scaler_sat
  import oscale_pkg::*;
#(
  parameter int IN_W      = 15,
  parameter int OUT_W     = 12,
  parameter int SEL_W     = 2,
  parameter int BLOCK_LEN = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] shiftSel,
  input  logic             inValid,
  input  logic             inBlockStart,
  input  logic [IN_W-1:0]  inRe,
  input  logic [IN_W-1:0]  inIm,
  output logic             outValid,
  output logic [OUT_W-1:0] outRe,
  output logic [OUT_W-1:0] outIm,
  output logic             outOvf
);

  scaleStrobe_t strobe;

  oscale_ctrl #(
    .BLOCK_LEN(BLOCK_LEN)
  ) uCtrl (
    .clk         (clk),
    .rst         (rst),
    .inValid     (inValid),
    .inBlockStart(inBlockStart),
    .strobe      (strobe)
  );

  oscale_dp #(
    .IN_W (IN_W),
    .OUT_W(OUT_W),
    .SEL_W(SEL_W)
  ) uDp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .sel     (shiftSel),
    .inRe    (inRe),
    .inIm    (inIm),
    .outRe   (outRe),
    .outIm   (outIm),
    .outValid(outValid),
    .outOvf  (outOvf)
  );

endmodule

// File: tb/test_out_scaler_sat.sv
module test_out_scaler_sat;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  shiftSel = '0;
  logic        inValid = 1'b0;
  logic        inBlockStart = 1'b0;
  logic [14:0] inRe = '0;
  logic [14:0] inIm = '0;
  logic        outValid;
  logic [11:0] outRe;
  logic [11:0] outIm;
  logic        outOvf;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  out_scaler_sat i_out_scaler_sat (
    .clk(clk), .rst(rst), .shiftSel(shiftSel), .inValid(inValid),
    .inBlockStart(inBlockStart), .inRe(inRe), .inIm(inIm),
    .outValid(outValid), .outRe(outRe), .outIm(outIm), .outOvf(outOvf)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [14:0] re;
    logic [14:0] im;
    logic [11:0] expRe;
    logic [11:0] expIm;
    logic        expOvf;
  } vec_t;

  // Each vector is applied as the first sample of its own block (R3..R8, R10)
  localparam vec_t VECS [8] = '{
    '{2'd0, 15'h1238, 15'h7000, 12'h247, 12'hE00, 1'b0},
    '{2'd1, 15'h0FFC, 15'h2000, 12'h3FF, 12'h7FF, 1'b1},
    '{2'd2, 15'h7000, 15'h0FFE, 12'h800, 12'h7FF, 1'b0},
    '{2'd3, 15'h4000, 15'h07FF, 12'h800, 12'h7FF, 1'b1},
    '{2'd3, 15'h7800, 15'h0800, 12'h800, 12'h7FF, 1'b1},
    '{2'd0, 15'h4000, 15'h3FFF, 12'h800, 12'h7FF, 1'b0},
    '{2'd1, 15'h5FFF, 15'h6000, 12'h800, 12'h800, 1'b1},
    '{2'd2, 15'h0003, 15'h7FFF, 12'h001, 12'hFFF, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive one cycle, land on the next falling edge
  task automatic put(input logic [1:0] sel, input logic [14:0] re, input logic [14:0] im,
                     input logic start, input logic valid);
    shiftSel = sel; inRe = re; inIm = im; inBlockStart = start; inValid = valid;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [11:0] heldRe;
    logic [11:0] heldIm;
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 outValid", 32'(outValid), 0);
    check("R1 outOvf", 32'(outOvf), 0);
    check("R1 outRe", 32'(outRe), 0);
    check("R1 outIm", 32'(outIm), 0);
    rst = 1'b0;
    @(negedge clk);

    // Vector table (R3, R4, R5, R6, R7, R8, R10)
    for (int i = 0; i < 8; i++) begin
      put(VECS[i].sel, VECS[i].re, VECS[i].im, 1'b1, 1'b1);
      check($sformatf("R2 valid v%0d", i), 32'(outValid), 1);
      check($sformatf("R3 re v%0d", i), 32'(outRe), 32'(VECS[i].expRe));
      check($sformatf("R7 im v%0d", i), 32'(outIm), 32'(VECS[i].expIm));
      check($sformatf("R10 ovf v%0d", i), 32'(outOvf), 32'(VECS[i].expOvf));
    end

    // R12: idle cycle with an out-of-range value on the inputs
    heldRe = outRe; heldIm = outIm;
    put(2'd3, 15'h4000, 15'h2000, 1'b1, 1'b0);
    check("R2 idle valid", 32'(outValid), 0);
    check("R12 idle re", 32'(outRe), 32'(heldRe));
    check("R12 idle im", 32'(outIm), 32'(heldIm));
    check("R12 idle ovf", 32'(outOvf), 0);

    // R9: overflow at block start, then in-range samples keep the flag
    put(2'd3, 15'h4000, 15'h0000, 1'b1, 1'b1);
    check("R8 start ovf", 32'(outOvf), 1);
    for (int k = 1; k < 64; k++) begin
      put(2'd3, 15'h0005, 15'h0000, 1'b0, 1'b1);
      if (k == 1 || k == 63) begin
        check("R9 sticky ovf", 32'(outOvf), 1);
        check("R9 data in range", 32'(outRe), 32'h005);
      end
    end
    // R11: 65th sample without a marker opens a block and clears the flag
    put(2'd3, 15'h0006, 15'h0000, 1'b0, 1'b1);
    check("R11 implicit start ovf", 32'(outOvf), 0);
    check("R11 implicit start re", 32'(outRe), 32'h006);

    // R9: overflow in mid-block sets the flag and later in-range samples keep it
    put(2'd3, 15'h0001, 15'h0800, 1'b0, 1'b1);
    check("R8 mid ovf", 32'(outOvf), 1);
    check("R7 mid re", 32'(outRe), 32'h001);
    check("R5 mid im", 32'(outIm), 32'h7FF);
    put(2'd3, 15'h0002, 15'h0000, 1'b0, 1'b1);
    check("R9 after mid ovf", 32'(outOvf), 1);

    // R10: explicit start in range clears; explicit start with overflow sets
    put(2'd1, 15'h0010, 15'h0000, 1'b1, 1'b1);
    check("R10 clear", 32'(outOvf), 0);
    check("R3 code1 re", 32'(outRe), 32'h004);
    put(2'd2, 15'h0000, 15'h6000, 1'b1, 1'b1);
    check("R10 set", 32'(outOvf), 1);
    check("R6 start im", 32'(outIm), 32'h800);

    // R11: block of 64 that ends in an overflow, next unmarked sample overflows too
    put(2'd0, 15'h0008, 15'h0000, 1'b1, 1'b1);
    check("R4 code0 ovf", 32'(outOvf), 0);
    for (int k = 1; k < 63; k++) put(2'd0, 15'h0008, 15'h0000, 1'b0, 1'b1);
    put(2'd3, 15'h3000, 15'h0000, 1'b0, 1'b1);
    check("R8 last sample ovf", 32'(outOvf), 1);
    put(2'd3, 15'h0000, 15'h4000, 1'b0, 1'b1);
    check("R11 wrap with ovf", 32'(outOvf), 1);
    check("R6 wrap im", 32'(outIm), 32'h800);
    put(2'd3, 15'h0000, 15'h0000, 1'b0, 1'b0);
    check("R2 tail valid", 32'(outValid), 0);

    // R1: asynchronous reset mid-stream
    #2 rst = 1'b1;
    #1;
    check("R1 async ovf", 32'(outOvf), 0);
    check("R1 async im", 32'(outIm), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule